// File: doc/BRIEF.md
# Shared Counter and Per-Core Compare Timer

This block holds one free-running 64-bit counter that every core in a cluster reads, and beside it a set of per-core timer slots. Each slot keeps a 64-bit compare value, a sticky timer-pending flag and a routing entry. The routing entry can steer that core's timer event onto one of several interrupt pins. Software reaches all of it through one 32-bit word interface. On each access the requesting core gives its index along with the address.

Address bits [5:4] pick a window: 0 is shared, 1 is local, 2 is other, and 3 is unused. Bits [3:0] pick a word inside the window. The shared window shows the counter as two read-only halves. The local window reaches the requesting core's own slot. The other window reaches whichever slot the requester has named in its own selector word. Each slot also reports, through a read-only control word, whether its timer and its performance-counter interrupts may be routed to a pin. Those capabilities are fixed by parameters.

Top module: `shared_timer`

## Requirements
- R1: Reset loads the counter with the parameter CNT_INIT, which defaults to zero. After reset the counter grows by exactly one on every clock. Shared word 0 reads bits 31..0 of the counter and shared word 1 reads bits 63..32.
- R2: When the low 32 bits of the counter wrap from all ones to zero, the high half rises by one on the same clock.
- R3: Writes to the shared window have no effect on the counter. Shared words other than 0 and 1 read as zero.
- R4: In each slot, word 2 holds compare bits 31..0 and word 3 holds compare bits 63..32. Both halves are writable and read back what was written. After reset the compare value is all ones.
- R5: A slot's pending flag is set on the clock after the counter equals that slot's compare value. The flag stays set, and it appears both on timer_pend[core] and on bit 0 of slot word 1.
- R6: A write to either compare half clears the slot's pending flag. If that write lands in the cycle where the counter matches, the write wins. A compare value written one count ahead of the counter fires exactly once, and one that the counter has already passed does not fire.
- R7: Slot word 4 is the route. Bit 31 enables routing and bits 4..0 hold a pin number. pin_out[core*NUM_PINS+pin] is high exactly while the flag is pending, routing is enabled and the pin number is below NUM_PINS. A pin number at or above NUM_PINS drives no pin.
- R8: Slot word 0 is read-only. Bit 0 gives the timer-routable capability (TMR_RT[core]) and bit 1 gives the performance-counter-routable capability (PERF_RT[core]). In a slot without timer capability, the route enable bit always reads 0 and the slot drives no pin. Writes to words 0 and 1 are ignored.
- R9: Local word 5 is the requester's selector, and it reads back the value written. Window 2 accesses the slot whose index the selector holds.
- R10: If the selector names a core that does not exist, window-2 reads return zero and window-2 writes change nothing. Addresses in window 3 read zero and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_core | input | CIDX_W | Index of the core making the access |
| reg_addr | input | 6 | Window in [5:4], word in [3:0] |
| reg_wr | input | 1 | Write strobe for the current access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address, combinational |
| timer_pend | output | NUM_CORES | Pending flag of each slot |
| pin_out | output | NUM_CORES*NUM_PINS | Routed timer interrupt pins, grouped by core |

## Verification
The bench builds the block with three cores, six pins and a start count of 0x0000_0000_FFFF_FF00. Starting just below the low-half wrap lets the carry into the high half be seen within a few hundred cycles. Three cores leave a 2-bit core index with one unused code, and selector value 5 names no core, so the out-of-range paths can be reached. The capability masks are set so that core 1 cannot route its timer, which lets the bench compare a routed slot against a blocked one. Pin number 7 lies beyond the six pins and exercises the drive-nothing case.

// File: rtl/stmr_pkg.sv
package stmr_pkg;

    localparam int WORD_W      = 32;
    localparam int CNT_W       = 64;
    localparam int SEL_W       = 8;
    localparam int PIN_FIELD_W = 5;
    localparam int ADDR_W      = 6;
    localparam int ROUTE_EN_B  = 31;

    typedef enum logic [1:0] {
        RGN_SHARED = 2'd0,
        RGN_LOCAL  = 2'd1,
        RGN_OTHER  = 2'd2,
        RGN_VOID   = 2'd3
    } region_e;

    // shared window words
    localparam logic [3:0] SH_CNT_LO = 4'd0;
    localparam logic [3:0] SH_CNT_HI = 4'd1;

    // per-slot window words
    localparam logic [3:0] SL_CAPS   = 4'd0;
    localparam logic [3:0] SL_PEND   = 4'd1;
    localparam logic [3:0] SL_CMP_LO = 4'd2;
    localparam logic [3:0] SL_CMP_HI = 4'd3;
    localparam logic [3:0] SL_ROUTE  = 4'd4;
    localparam logic [3:0] SL_SEL    = 4'd5;

    typedef struct packed {
        region_e    region;
        logic [3:0] word;
    } addr_fields_t;

    typedef struct packed {
        logic                   en;
        logic [PIN_FIELD_W-1:0] pin;
    } route_t;

    function automatic addr_fields_t split_addr(input logic [ADDR_W-1:0] a);
        addr_fields_t f;
        f.region = region_e'(a[5:4]);
        f.word   = a[3:0];
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] route_word(input route_t r);
        logic [WORD_W-1:0] w;
        w                    = '0;
        w[ROUTE_EN_B]        = r.en;
        w[PIN_FIELD_W-1:0]   = r.pin;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] count_half(input logic [CNT_W-1:0] c,
                                                     input logic upper);
        return upper ? c[CNT_W-1:WORD_W] : c[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/stmr_counter.sv
module stmr_counter #(
    parameter int                 WIDTH = 64,
    parameter logic [WIDTH-1:0]   INIT  = '0
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] cnt
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= INIT;
        else     cnt_q <= cnt_q + WIDTH'(1);
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/stmr_decode.sv
module stmr_decode
    import stmr_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CIDX_W    = 2
) (
    input  logic [CIDX_W-1:0]          req_core,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [NUM_CORES*SEL_W-1:0] sel_flat,
    output addr_fields_t               fields,
    output logic [NUM_CORES-1:0]       hit
);
    logic             req_ok;
    logic [SEL_W-1:0] own_sel;

    always_comb begin
        fields  = split_addr(addr);
        req_ok  = 1'b0;
        own_sel = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (req_core == CIDX_W'(i)) begin
                req_ok  = 1'b1;
                own_sel = sel_flat[i*SEL_W +: SEL_W];
            end
        end
        hit = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            unique case (fields.region)
                RGN_LOCAL: hit[i] = req_ok && (req_core == CIDX_W'(i));
                RGN_OTHER: hit[i] = req_ok && (own_sel == SEL_W'(i));
                default:   hit[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/stmr_slot.sv
module stmr_slot
    import stmr_pkg::*;
#(
    parameter int NUM_PINS      = 6,
    parameter bit TMR_ROUTABLE  = 1'b1,
    parameter bit PERF_ROUTABLE = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CNT_W-1:0]    cnt,
    input  logic                acc_hit,
    input  logic                acc_local,
    input  logic                acc_wr,
    input  logic [3:0]          acc_word,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rd_word,
    output logic                pend,
    output logic [NUM_PINS-1:0] pins,
    output logic [SEL_W-1:0]    sel,
    output logic [CNT_W-1:0]    cmp,
    output logic                cmp_wr
);
    logic [CNT_W-1:0] cmp_q;
    logic             pend_q;
    route_t           route_q;
    logic [SEL_W-1:0] sel_q;

    logic wr_go, wr_lo, wr_hi, wr_route, wr_sel, match_now;

    assign wr_go     = acc_hit & acc_wr;
    assign wr_lo     = wr_go && (acc_word == SL_CMP_LO);
    assign wr_hi     = wr_go && (acc_word == SL_CMP_HI);
    assign wr_route  = wr_go && (acc_word == SL_ROUTE);
    assign wr_sel    = wr_go && acc_local && (acc_word == SL_SEL);
    assign match_now = (cnt == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q   <= '1;
            pend_q  <= 1'b0;
            route_q <= '0;
            sel_q   <= '0;
        end else begin
            if (wr_lo) cmp_q[WORD_W-1:0]     <= wdata;
            if (wr_hi) cmp_q[CNT_W-1:WORD_W] <= wdata;
            // a new compare value always restarts the event
            pend_q <= (wr_lo | wr_hi) ? 1'b0 : (pend_q | match_now);
            if (wr_route) begin
                route_q.en  <= wdata[ROUTE_EN_B] & TMR_ROUTABLE;
                route_q.pin <= wdata[PIN_FIELD_W-1:0];
            end
            if (wr_sel) sel_q <= wdata[SEL_W-1:0];
        end
    end

    always_comb begin
        rd_word = '0;
        unique case (acc_word)
            SL_CAPS: begin
                rd_word[0] = TMR_ROUTABLE;
                rd_word[1] = PERF_ROUTABLE;
            end
            SL_PEND:   rd_word[0] = pend_q;
            SL_CMP_LO: rd_word    = count_half(cmp_q, 1'b0);
            SL_CMP_HI: rd_word    = count_half(cmp_q, 1'b1);
            SL_ROUTE:  rd_word    = route_word(route_q);
            SL_SEL:    rd_word    = acc_local ? WORD_W'(sel_q) : '0;
            default:   rd_word    = '0;
        endcase
    end

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            assign pins[p] = pend_q & route_q.en & (route_q.pin == PIN_FIELD_W'(p));
        end
    endgenerate

    assign pend   = pend_q;
    assign sel    = sel_q;
    assign cmp    = cmp_q;
    assign cmp_wr = wr_lo | wr_hi;
endmodule

// File: rtl/shared_timer.sv
module shared_timer
    import stmr_pkg::*;
#(
    parameter int                      NUM_CORES = 4,
    parameter int                      NUM_PINS  = 6,
    parameter logic [CNT_W-1:0]        CNT_INIT  = '0,
    parameter logic [NUM_CORES-1:0]    TMR_RT    = '1,
    parameter logic [NUM_CORES-1:0]    PERF_RT   = '1,
    localparam int                     CIDX_W    = $clog2(NUM_CORES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [CIDX_W-1:0]             req_core,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic                          reg_wr,
    input  logic [WORD_W-1:0]             reg_wdata,
    output logic [WORD_W-1:0]             reg_rdata,
    output logic [NUM_CORES-1:0]          timer_pend,
    output logic [NUM_CORES*NUM_PINS-1:0] pin_out
);
    logic [CNT_W-1:0]           cnt;
    logic [NUM_CORES*SEL_W-1:0] sel_flat;
    logic [NUM_CORES*CNT_W-1:0] cmp_flat;
    logic [NUM_CORES-1:0]       cmp_wr;
    logic [NUM_CORES-1:0]       hit;
    logic [WORD_W-1:0]          slot_rd [NUM_CORES];
    addr_fields_t               fields;
    logic                       is_local;

    stmr_counter #(.WIDTH(CNT_W), .INIT(CNT_INIT)) u_count (
        .clk (clk),
        .rst (rst),
        .cnt (cnt)
    );

    stmr_decode #(.NUM_CORES(NUM_CORES), .CIDX_W(CIDX_W)) u_dec (
        .req_core (req_core),
        .addr     (reg_addr),
        .sel_flat (sel_flat),
        .fields   (fields),
        .hit      (hit)
    );

    assign is_local = (fields.region == RGN_LOCAL);

    generate
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
            stmr_slot #(
                .NUM_PINS      (NUM_PINS),
                .TMR_ROUTABLE  (TMR_RT[c]),
                .PERF_ROUTABLE (PERF_RT[c])
            ) u_slot (
                .clk       (clk),
                .rst       (rst),
                .cnt       (cnt),
                .acc_hit   (hit[c]),
                .acc_local (is_local),
                .acc_wr    (reg_wr),
                .acc_word  (fields.word),
                .wdata     (reg_wdata),
                .rd_word   (slot_rd[c]),
                .pend      (timer_pend[c]),
                .pins      (pin_out[c*NUM_PINS +: NUM_PINS]),
                .sel       (sel_flat[c*SEL_W +: SEL_W]),
                .cmp       (cmp_flat[c*CNT_W +: CNT_W]),
                .cmp_wr    (cmp_wr[c])
            );
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        if (fields.region == RGN_SHARED) begin
            if (fields.word == SH_CNT_LO)      reg_rdata = count_half(cnt, 1'b0);
            else if (fields.word == SH_CNT_HI) reg_rdata = count_half(cnt, 1'b1);
        end else begin
            for (int c = 0; c < NUM_CORES; c++)
                if (hit[c]) reg_rdata = reg_rdata | slot_rd[c];
        end
    end
endmodule

// File: rtl/shared_timer_chk.sv
module shared_timer_chk #(
    parameter int                   NUM_CORES = 4,
    parameter int                   NUM_PINS  = 6,
    parameter logic [NUM_CORES-1:0] TMR_RT    = '1
) (
    input logic                          clk,
    input logic                          rst,
    input logic [63:0]                   cnt,
    input logic [NUM_CORES*64-1:0]       cmp_flat,
    input logic [NUM_CORES-1:0]          cmp_wr,
    input logic [NUM_CORES-1:0]          timer_pend,
    input logic [NUM_CORES*NUM_PINS-1:0] pin_out
);
    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt == $past(cnt) + 64'd1);

    generate
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
            // R5
            pend_rise_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(timer_pend[c]) |-> $past(cnt == cmp_flat[c*64 +: 64]));
            // R5
            pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
                ($past(timer_pend[c]) && !$past(cmp_wr[c])) |-> timer_pend[c]);
            // R6
            cmp_clear_chk: assert property (@(posedge clk) disable iff (rst)
                $past(cmp_wr[c]) |-> !timer_pend[c]);
            // R7
            pin_single_chk: assert property (@(posedge clk) disable iff (rst)
                $onehot0(pin_out[c*NUM_PINS +: NUM_PINS]));
            // R7
            pin_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
                (pin_out[c*NUM_PINS +: NUM_PINS] != '0) |-> timer_pend[c]);
            if (!TMR_RT[c]) begin : g_blocked
                // R8
                pin_blocked_chk: assert property (@(posedge clk) disable iff (rst)
                    pin_out[c*NUM_PINS +: NUM_PINS] == '0);
            end
        end
    endgenerate
endmodule

bind shared_timer shared_timer_chk #(
    .NUM_CORES (NUM_CORES),
    .NUM_PINS  (NUM_PINS),
    .TMR_RT    (TMR_RT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt        (cnt),
    .cmp_flat   (cmp_flat),
    .cmp_wr     (cmp_wr),
    .timer_pend (timer_pend),
    .pin_out    (pin_out)
);

// File: tb/shared_timer_test.sv
`timescale 1ns/1ps
module shared_timer_test;
    localparam int          NC    = 3;
    localparam int          NP    = 6;
    localparam logic [63:0] INIT  = 64'h0000_0000_FFFF_FF00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  req_core = '0;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NC-1:0]    timer_pend;
    logic [NC*NP-1:0] pin_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [63:0] ref_cnt;

    always #2 clk = ~clk;

    shared_timer #(
        .NUM_CORES (NC),
        .NUM_PINS  (NP),
        .CNT_INIT  (INIT),
        .TMR_RT    (3'b101),
        .PERF_RT   (3'b011)
    ) uut (
        .clk (clk), .rst (rst), .req_core (req_core), .reg_addr (reg_addr),
        .reg_wr (reg_wr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .timer_pend (timer_pend), .pin_out (pin_out)
    );

    // reference count from R1
    always @(posedge clk) begin
        if (rst) ref_cnt <= INIT;
        else     ref_cnt <= ref_cnt + 64'd1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // each access takes one cycle: starts and ends at a falling edge
    task automatic wr(input logic [1:0] c, input logic [5:0] a, input logic [31:0] d);
        req_core = c; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] c, input logic [5:0] a,
                      input logic [31:0] exp, input string tag);
        req_core = c; reg_addr = a; reg_wr = 1'b0;
        #1;
        chk(tag, reg_rdata, exp);
        @(negedge clk);
    endtask

    typedef struct packed {
        logic [1:0]  wc;
        logic [5:0]  wa;
        logic [31:0] wd;
        logic [1:0]  rc;
        logic [5:0]  ra;
        logic [31:0] ex;
        logic [3:0]  rq;
    } vec_t;

    localparam vec_t VEC [11] = '{
        '{2'd0, 6'h12, 32'h1234_5678, 2'd0, 6'h12, 32'h1234_5678, 4'd4},  // R4 low half
        '{2'd0, 6'h13, 32'h0000_00AB, 2'd0, 6'h13, 32'h0000_00AB, 4'd4},  // R4 high half
        '{2'd1, 6'h14, 32'h8000_0003, 2'd1, 6'h14, 32'h0000_0003, 4'd8},  // R8 enable refused
        '{2'd2, 6'h14, 32'h8000_0007, 2'd2, 6'h14, 32'h8000_0007, 4'd7},  // R7 route kept
        '{2'd0, 6'h15, 32'h0000_0002, 2'd0, 6'h15, 32'h0000_0002, 4'd9},  // R9 selector
        '{2'd0, 6'h22, 32'hCAFE_0001, 2'd2, 6'h12, 32'hCAFE_0001, 4'd9},  // R9 other window
        '{2'd0, 6'h10, 32'hFFFF_FFFF, 2'd0, 6'h10, 32'h0000_0003, 4'd8},  // R8 caps core0
        '{2'd1, 6'h11, 32'h0000_0001, 2'd1, 6'h10, 32'h0000_0002, 4'd8},  // R8 caps core1
        '{2'd0, 6'h15, 32'h0000_0005, 2'd0, 6'h22, 32'h0000_0000, 4'd10}, // R10 bad select read
        '{2'd0, 6'h22, 32'h1111_1111, 2'd2, 6'h12, 32'hCAFE_0001, 4'd10}, // R10 bad select write
        '{2'd1, 6'h3F, 32'h0000_FFFF, 2'd1, 6'h3F, 32'h0000_0000, 4'd10}  // R10 void window
    };

    initial begin
        logic [63:0] c0, tgt;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state
        rd(2'd0, 6'h00, INIT[31:0], "R1 reset lo");
        chk("R1 reset pend", 64'(timer_pend), 64'd0);
        chk("R7 reset pins", 64'(pin_out), 64'd0);
        rd(2'd0, 6'h12, 32'hFFFF_FFFF, "R4 reset compare");
        rst = 1'b0;
        @(negedge clk);
        rd(2'd0, 6'h00, ref_cnt[31:0], "R1 count lo");
        rd(2'd0, 6'h00, ref_cnt[31:0], "R1 count steps");
        rd(2'd1, 6'h01, ref_cnt[63:32], "R1 count hi");
        wr(2'd0, 6'h00, 32'h0);
        rd(2'd0, 6'h00, ref_cnt[31:0], "R3 counter write ignored");
        rd(2'd0, 6'h05, 32'h0, "R3 unused shared word");

        for (int i = 0; i < 11; i++) begin
            wr(VEC[i].wc, VEC[i].wa, VEC[i].wd);
            rd(VEC[i].rc, VEC[i].ra, VEC[i].ex, $sformatf("R%0d vector %0d", VEC[i].rq, i));
        end
        wr(2'd0, 6'h15, 32'h0000_0002);

        // R2 carry into high half
        while (ref_cnt[63:32] == 32'd0) @(negedge clk);
        rd(2'd2, 6'h01, ref_cnt[63:32], "R2 high after wrap");
        rd(2'd2, 6'h00, ref_cnt[31:0], "R2 low after wrap");
        chk("R2 high is one", ref_cnt[63:32], 64'd1);

        // R5/R6/R7: core0 routed to pin 2, compare two counts ahead
        wr(2'd0, 6'h14, 32'h8000_0002);
        c0 = ref_cnt; tgt = c0 + 64'd2;
        wr(2'd0, 6'h13, tgt[63:32]);
        wr(2'd0, 6'h12, tgt[31:0]);
        chk("R6 no early fire", 64'(timer_pend[0]), 64'd0);
        @(negedge clk);
        chk("R5 fires after match", 64'(timer_pend[0]), 64'd1);
        chk("R7 pin 2 routed", 64'(pin_out[0 +: NP]), 64'h04);
        repeat (20) @(negedge clk);
        chk("R5 stays pending", 64'(timer_pend[0]), 64'd1);
        rd(2'd0, 6'h11, 32'h1, "R5 pend word");

        // R6 write in the matching cycle wins
        c0 = ref_cnt; tgt = c0 + 64'd2;
        wr(2'd0, 6'h13, tgt[63:32]);
        chk("R6 write clears", 64'(timer_pend[0]), 64'd0);
        wr(2'd0, 6'h12, tgt[31:0]);
        wr(2'd0, 6'h13, tgt[63:32]);
        chk("R6 write beats match", 64'(timer_pend[0]), 64'd0);
        repeat (10) @(negedge clk);
        chk("R6 no later fire", 64'(timer_pend[0]), 64'd0);

        // R6 compare already passed never fires (core2 via own window)
        c0 = ref_cnt; tgt = c0 + 64'd1;
        wr(2'd2, 6'h13, tgt[63:32]);
        wr(2'd2, 6'h12, tgt[31:0]);
        repeat (10) @(negedge clk);
        chk("R6 passed compare silent", 64'(timer_pend[2]), 64'd0);

        // R7 core2 fires on pin 7, beyond the pins
        c0 = ref_cnt; tgt = c0 + 64'd2;
        wr(2'd2, 6'h13, tgt[63:32]);
        wr(2'd2, 6'h12, tgt[31:0]);
        repeat (2) @(negedge clk);
        chk("R7 core2 pending", 64'(timer_pend[2]), 64'd1);
        chk("R7 pin out of range", 64'(pin_out[2*NP +: NP]), 64'd0);

        // R8 core1 cannot route
        c0 = ref_cnt; tgt = c0 + 64'd2;
        wr(2'd1, 6'h13, tgt[63:32]);
        wr(2'd1, 6'h12, tgt[31:0]);
        repeat (2) @(negedge clk);
        chk("R8 core1 pending", 64'(timer_pend[1]), 64'd1);
        chk("R8 core1 pins quiet", 64'(pin_out[1*NP +: NP]), 64'd0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule